// File: doc/BRIEF.md
# Colour Palette Lookup with Auto-Increment Loader

This block is a colour lookup table for a display pipeline. It holds 256 entries of three bytes (red, green, blue). A host loads it over a narrow byte port: it first writes the index register to pick a starting entry, then streams bytes into the data register. Two small state machines track where the next byte goes. One handles writes and one handles reads. Each walks through the states COMP_RED, COMP_GREEN and COMP_BLUE. So a run of data-port accesses covers one component after another, and one entry after another, with no address phase per byte.

On the pixel side, every clock cycle a pixel is mapped through the table to a 24-bit RGB word. In direct mode each 8-bit channel picks its own entry. In packed 5-6-5 mode the red and blue fields reach only the first 32 entries, while the six-bit green field reaches the first 64. The data-port read path walks the table in the same component order, so software can verify a load.

Both pointer machines have the same transitions. COMP_RED goes to COMP_GREEN on a data access. COMP_GREEN goes to COMP_BLUE on a data access. COMP_BLUE goes to COMP_RED on a data access and advances the entry pointer. Any state goes to COMP_RED on an index write, which also loads the entry pointer.

Top module: `palette_lut`

## Requirements
- R1: The table holds 256 entries of three 8-bit components, and every byte written through the data port is stored and returned unchanged.
- R2: A host write with `host_sel`=0 loads the written value into both the write and the read entry pointers, and returns both component states to red, even partway through a triple.
- R3: Successive data writes (`host_sel`=1) fill red, then green, then blue of the current entry. After blue, the entry pointer advances by one.
- R4: The entry pointer wraps from 255 to 0 after the blue byte of entry 255.
- R5: Data reads (`host_rd` with `host_sel`=1) return bytes in red, green, blue order from a read pointer that data writes do not move. The byte appears on `host_rdata` one cycle after the read strobe, and `host_rdata` holds its value when there is no read.
- R6: With `pix_mode`=0, red indexes with `pix_in[23:16]`, green with `pix_in[15:8]` and blue with `pix_in[7:0]`. `rgb_out` is {red, green, blue}, with red in bits 23:16.
- R7: With `pix_mode`=1, red indexes with `pix_in[15:11]`, green with `pix_in[10:5]` and blue with `pix_in[4:0]`, each zero-extended. Bits 23:16 of `pix_in` are ignored.
- R8: `rgb_out` reflects the pixel presented one clock earlier. A table write lands in the cycle after the edge that stores it, so the next pixel sees it.
- R9: After reset, `rgb_out` and `host_rdata` are zero and both pointers are at entry 0, red.
- R10: A read with `host_sel`=0 returns the current write entry pointer one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_sel | input | 1 | 0 selects the index register, 1 the data register |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, registered |
| pix_mode | input | 1 | 0 direct 8-bit channels, 1 packed 5-6-5 |
| pix_in | input | 24 | Pixel to translate |
| rgb_out | output | 24 | Translated colour, one cycle later |

## Verification
A write pointer that has slipped by one component shows up as a rotated colour in the very next readback, or as a wrong channel on the first pixel that uses that entry. A write pointer that skips or repeats an entry shows up as a wrong index register value after the following triple. A packed-mode field slice taken from the wrong bits gives a wrong `rgb_out` on the first pixel whose fields differ, one cycle after it is presented. A read pointer that wrongly follows the writes returns bytes of the wrong entry as soon as reads and writes are interleaved.

// File: rtl/pal_pkg.sv
package pal_pkg;
    typedef enum logic [1:0] {
        COMP_RED   = 2'd0,
        COMP_GREEN = 2'd1,
        COMP_BLUE  = 2'd2
    } comp_t;

    typedef enum logic {
        MODE_DIRECT = 1'b0,
        MODE_PACKED = 1'b1
    } pix_mode_t;

    localparam int NUM_COMP = 3;
endpackage

// File: rtl/pal_loader.sv
module pal_loader
    import pal_pkg::*;
#(
    parameter int DW    = 8,
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idx_wr,
    input  logic             data_wr,
    input  logic [DW-1:0]    wdata,
    output logic [IDX_W-1:0] entry,
    output comp_t            comp,
    output logic             wr_en
);
    comp_t            next_comp;
    logic [IDX_W-1:0] next_entry;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            comp  <= COMP_RED;
            entry <= '0;
        end else begin
            comp  <= next_comp;
            entry <= next_entry;
        end
    end

    // next state and outputs
    always_comb begin
        next_comp  = comp;
        next_entry = entry;
        wr_en      = 1'b0;
        if (idx_wr) begin
            next_comp  = COMP_RED;
            next_entry = wdata[IDX_W-1:0];
        end else if (data_wr) begin
            wr_en = 1'b1;
            unique case (comp)
                COMP_RED:   next_comp = COMP_GREEN;
                COMP_GREEN: next_comp = COMP_BLUE;
                COMP_BLUE: begin
                    next_comp  = COMP_RED;
                    next_entry = entry + IDX_W'(1);
                end
                default:    next_comp = COMP_RED;
            endcase
        end
    end

    assert_idx_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        idx_wr |=> (entry == $past(wdata[IDX_W-1:0])) && (comp == COMP_RED));
    assert_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!idx_wr && data_wr && comp == COMP_RED) |=> comp == COMP_GREEN);
    assert_entry_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!idx_wr && !(data_wr && comp == COMP_BLUE)) |=> $stable(entry));
    assert_entry_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!idx_wr && data_wr && comp == COMP_BLUE) |=> entry == $past(entry) + IDX_W'(1));
endmodule

// File: rtl/pal_reader.sv
module pal_reader
    import pal_pkg::*;
#(
    parameter int DW    = 8,
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DW-1:0]    load_val,
    input  logic             step,
    output logic [IDX_W-1:0] entry,
    output comp_t            comp
);
    comp_t            next_comp;
    logic [IDX_W-1:0] next_entry;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            comp  <= COMP_RED;
            entry <= '0;
        end else begin
            comp  <= next_comp;
            entry <= next_entry;
        end
    end

    always_comb begin
        next_comp  = comp;
        next_entry = entry;
        if (load) begin
            next_comp  = COMP_RED;
            next_entry = load_val[IDX_W-1:0];
        end else if (step) begin
            unique case (comp)
                COMP_RED:   next_comp = COMP_GREEN;
                COMP_GREEN: next_comp = COMP_BLUE;
                COMP_BLUE: begin
                    next_comp  = COMP_RED;
                    next_entry = entry + IDX_W'(1);
                end
                default:    next_comp = COMP_RED;
            endcase
        end
    end

    assert_rd_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(entry) && $stable(comp));
    assert_rd_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (entry == $past(load_val[IDX_W-1:0])) && (comp == COMP_RED));
endmodule

// File: rtl/pal_store.sv
module pal_store
    import pal_pkg::*;
#(
    parameter int DW      = 8,
    parameter int IDX_W   = 8,
    parameter int ENTRIES = 256
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  comp_t                     wr_comp,
    input  logic [IDX_W-1:0]          wr_addr,
    input  logic [DW-1:0]             wr_data,
    input  comp_t                     rd_comp,
    input  logic [IDX_W-1:0]          rd_addr,
    output logic [DW-1:0]             rd_byte,
    input  logic [NUM_COMP*IDX_W-1:0] lk_idx,
    output logic [NUM_COMP*DW-1:0]    lk_q
);
    logic [NUM_COMP*DW-1:0] host_bus;

    for (genvar c = 0; c < NUM_COMP; c++) begin : g_chan
        logic [DW-1:0] mem [ENTRIES];
        logic [DW-1:0] q;

        always_ff @(posedge clk) begin
            if (wr_en && wr_comp == comp_t'(c))
                mem[wr_addr] <= wr_data;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) q <= '0;
            else        q <= mem[lk_idx[c*IDX_W +: IDX_W]];
        end

        assign lk_q[c*DW +: DW]     = q;
        assign host_bus[c*DW +: DW] = mem[rd_addr];
    end

    always_comb begin
        unique case (rd_comp)
            COMP_RED:   rd_byte = host_bus[0*DW +: DW];
            COMP_GREEN: rd_byte = host_bus[1*DW +: DW];
            COMP_BLUE:  rd_byte = host_bus[2*DW +: DW];
            default:    rd_byte = '0;
        endcase
    end
endmodule

// File: rtl/palette_lut.sv
module palette_lut
    import pal_pkg::*;
#(
    parameter int DW      = 8,
    parameter int ENTRIES = 256
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            host_wr,
    input  logic            host_rd,
    input  logic            host_sel,
    input  logic [DW-1:0]   host_wdata,
    output logic [DW-1:0]   host_rdata,
    input  logic            pix_mode,
    input  logic [3*DW-1:0] pix_in,
    output logic [3*DW-1:0] rgb_out
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int PK_R  = 5;
    localparam int PK_G  = 6;
    localparam int PK_B  = 5;
    localparam int PK_GL = PK_B;
    localparam int PK_RL = PK_B + PK_G;

    logic             idx_wr, data_wr, data_rd;
    logic [IDX_W-1:0] w_entry, r_entry;
    comp_t            w_comp, r_comp;
    logic             w_en;
    logic [DW-1:0]    rd_byte;
    logic [NUM_COMP*IDX_W-1:0] lk_idx;
    logic [NUM_COMP*DW-1:0]    lk_q;
    pix_mode_t        mode;

    assign idx_wr  = host_wr & ~host_sel;
    assign data_wr = host_wr &  host_sel;
    assign data_rd = host_rd &  host_sel;
    assign mode    = pix_mode_t'(pix_mode);

    pal_loader #(.DW(DW), .IDX_W(IDX_W)) u_loader (
        .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .data_wr(data_wr),
        .wdata(host_wdata), .entry(w_entry), .comp(w_comp), .wr_en(w_en)
    );

    pal_reader #(.DW(DW), .IDX_W(IDX_W)) u_reader (
        .clk(clk), .rst_n(rst_n), .load(idx_wr), .load_val(host_wdata),
        .step(data_rd), .entry(r_entry), .comp(r_comp)
    );

    // pixel field extraction: slot 0 red, 1 green, 2 blue
    always_comb begin
        unique case (mode)
            MODE_DIRECT: begin
                lk_idx[0*IDX_W +: IDX_W] = pix_in[2*DW +: IDX_W];
                lk_idx[1*IDX_W +: IDX_W] = pix_in[1*DW +: IDX_W];
                lk_idx[2*IDX_W +: IDX_W] = pix_in[0*DW +: IDX_W];
            end
            MODE_PACKED: begin
                lk_idx[0*IDX_W +: IDX_W] = IDX_W'(pix_in[PK_RL +: PK_R]);
                lk_idx[1*IDX_W +: IDX_W] = IDX_W'(pix_in[PK_GL +: PK_G]);
                lk_idx[2*IDX_W +: IDX_W] = IDX_W'(pix_in[0 +: PK_B]);
            end
            default: lk_idx = '0;
        endcase
    end

    pal_store #(.DW(DW), .IDX_W(IDX_W), .ENTRIES(ENTRIES)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(w_en), .wr_comp(w_comp), .wr_addr(w_entry), .wr_data(host_wdata),
        .rd_comp(r_comp), .rd_addr(r_entry), .rd_byte(rd_byte),
        .lk_idx(lk_idx), .lk_q(lk_q)
    );

    assign rgb_out = {lk_q[0*DW +: DW], lk_q[1*DW +: DW], lk_q[2*DW +: DW]};

    always_ff @(posedge clk) begin
        if (!rst_n)       host_rdata <= '0;
        else if (host_rd) host_rdata <= host_sel ? rd_byte : DW'(w_entry);
    end

    assert_rdata_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |=> $stable(host_rdata));
    assert_wr_rd_indep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !host_rd) |=> $stable(r_entry) && $stable(r_comp));
endmodule

// File: tb/test_palette_lut.sv
module test_palette_lut;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0, host_rd = 1'b0, host_sel = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        pix_mode = 1'b0;
    logic [23:0] pix_in = '0;
    logic [23:0] rgb_out;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    logic [7:0] mr [256];
    logic [7:0] mg [256];
    logic [7:0] mb [256];
    int wp = 0, wc = 0, rp = 0, rc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    palette_lut i_palette_lut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .pix_mode(pix_mode), .pix_in(pix_in), .rgb_out(rgb_out)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_index(logic [7:0] v);
        @(negedge clk);
        host_wr = 1'b1; host_sel = 1'b0; host_wdata = v;
        @(negedge clk);
        host_wr = 1'b0;
        wp = v; wc = 0; rp = v; rc = 0;
    endtask

    task automatic wr_data(logic [7:0] v);
        @(negedge clk);
        host_wr = 1'b1; host_sel = 1'b1; host_wdata = v;
        @(negedge clk);
        host_wr = 1'b0;
        case (wc)
            0: mr[wp] = v;
            1: mg[wp] = v;
            default: mb[wp] = v;
        endcase
        if (wc == 2) begin wc = 0; wp = (wp + 1) % 256; end
        else wc++;
    endtask

    task automatic rd_port(logic sel, output logic [7:0] v);
        @(negedge clk);
        host_rd = 1'b1; host_sel = sel;
        @(negedge clk);
        host_rd = 1'b0;
        v = host_rdata;
    endtask

    function automatic logic [7:0] exp_data_byte();
        case (rc)
            0: return mr[rp];
            1: return mg[rp];
            default: return mb[rp];
        endcase
    endfunction

    task automatic rd_data_check(string req);
        logic [7:0] v;
        logic [7:0] e;
        e = exp_data_byte();
        rd_port(1'b1, v);
        check(req, {24'd0, v}, {24'd0, e});
        if (rc == 2) begin rc = 0; rp = (rp + 1) % 256; end
        else rc++;
    endtask

    function automatic logic [23:0] exp_rgb(logic m, logic [23:0] p);
        int r, g, b;
        if (m) begin r = p[15:11]; g = p[10:5]; b = p[4:0]; end
        else   begin r = p[23:16]; g = p[15:8]; b = p[7:0]; end
        return {mr[r], mg[g], mb[b]};
    endfunction

    task automatic pix_check(string req, logic m, logic [23:0] p);
        @(negedge clk);
        pix_mode = m; pix_in = p;
        @(negedge clk);
        check(req, {8'd0, rgb_out}, {8'd0, exp_rgb(m, p)});
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd715));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        check("R9 rgb_out", {8'd0, rgb_out}, 32'd0);
        check("R9 host_rdata", {24'd0, host_rdata}, 32'd0);
        rd_port(1'b0, v);
        check("R9 R10 index after reset", {24'd0, v}, 32'd0);

        // R1 R3 R4: load full table with random bytes from entry 0
        wr_index(8'd0);
        for (int i = 0; i < 768; i++) wr_data(8'($urandom));
        rd_port(1'b0, v);
        check("R4 pointer wrapped to 0", {24'd0, v}, 32'd0);

        // R1 R5: read back whole table
        wr_index(8'd0);
        for (int i = 0; i < 768; i++) rd_data_check("R1 R5 readback");

        // R6: direct mode random pixels
        for (int i = 0; i < 150; i++) pix_check("R6 direct lookup", 1'b0, 24'($urandom));

        // R5: read pointer independent of writes
        wr_index(8'd10);
        rd_data_check("R5 interleave red");
        rd_data_check("R5 interleave green");
        wr_data(8'h3C); wr_data(8'h5A); wr_data(8'hC3);
        rd_data_check("R5 interleave blue after writes");
        rd_port(1'b0, v);
        check("R10 R3 write pointer advanced", {24'd0, v}, 32'd11);

        // R2: index write mid-triple restarts at red
        wr_index(8'd5);
        wr_data(8'hA1); wr_data(8'hA2);
        wr_index(8'd7);
        wr_data(8'hB1);
        wr_index(8'd7);
        rd_data_check("R2 restart at red");
        wr_index(8'd5);
        rd_data_check("R2 partial red");
        rd_data_check("R2 partial green");
        rd_data_check("R2 untouched blue");

        // R4: wrap 255 -> 0
        wr_index(8'd255);
        wr_data(8'h11); wr_data(8'h22); wr_data(8'h33);
        rd_port(1'b0, v);
        check("R4 wrap index", {24'd0, v}, 32'd0);
        wr_data(8'h44);
        wr_index(8'd0);
        rd_data_check("R4 byte after wrap lands at entry 0 red");

        // R7: 5-6-5 identity ramp
        wr_index(8'd0);
        for (int i = 0; i < 64; i++) begin
            if (i < 32) begin
                wr_data(8'(i*8 + i/4)); wr_data(8'(i*4 + i/16)); wr_data(8'(i*8 + i/4));
            end else begin
                wr_data(8'd0); wr_data(8'(i*4 + i/16)); wr_data(8'd0);
            end
        end
        @(negedge clk); pix_mode = 1'b1; pix_in = 24'hAB_FFFF;
        @(negedge clk);
        check("R7 packed white", {8'd0, rgb_out}, 32'h00FF_FFFF);
        @(negedge clk); pix_in = 24'h00_07E0;
        @(negedge clk);
        check("R7 packed green only", {8'd0, rgb_out}, 32'h0000_FF00);
        @(negedge clk); pix_in = 24'h5A_0000;
        @(negedge clk);
        check("R7 packed black, upper bits ignored", {8'd0, rgb_out}, 32'd0);
        for (int i = 0; i < 150; i++) pix_check("R7 packed lookup", 1'b1, 24'($urandom));

        // R8: write becomes visible on the next pixel
        @(negedge clk); pix_mode = 1'b0; pix_in = 24'h030303;
        wr_index(8'd3);
        wr_data(8'h01); wr_data(8'h02);
        v = mb[3];
        wr_data(8'hEE);
        check("R8 old blue before write lands", {8'd0, rgb_out}, {8'd0, 8'h01, 8'h02, v});
        @(negedge clk);
        check("R8 new blue next pixel", {8'd0, rgb_out}, 32'h0001_02EE);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule